// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers interrupt requests for a small fixed-point signal processor and presents one request, with a vector number, to the instruction sequencer. Six sources can be masked. Three of them come from active-low external pins, and each pin can be set for edge or level sensing. The other three are single-cycle strobes from on-chip peripherals: timer underflow, serial receive complete and serial transmit complete. A seventh source is a software trap, and it cannot be masked.

Software controls the block through a mask register with one bit per maskable source and a global enable bit. The sequencer takes a request by pulsing an acknowledge while the request is shown. That pulse does two things. It clears the pending flag of the source being serviced, and it drops the global enable so that a second maskable interrupt cannot nest. The software trap ignores both the mask and the global enable, and it wins over every maskable source.

Top module: `intc_core`

## Requirements
- R1: After reset, `irq_req` is 0, `mask_q` is 0 and `gie_q` is 0.
- R2: When an external pin is in edge mode (`ext_edge_sel` bit = 1), a high-to-low transition on that pin latches one pending request. The request is visible on the third rising edge after the pin falls. It stays pending after the pin returns high. One transition produces exactly one request, even if the pin then stays low.
- R3: When an external pin is in level mode (`ext_edge_sel` bit = 0), its request follows the pin after two-flop synchronisation. The request appears two rising edges after the pin goes low and leaves two rising edges after the pin goes high. An acknowledge does not clear it.
- R4: A one-cycle strobe on `tmr_uflow`, `sp_rx_done` or `sp_tx_done` sets a pending request that is visible after the next rising edge.
- R5: Mask bit positions are: bit 0 = pin 0, bit 1 = pin 1, bit 2 = pin 2, bit 3 = timer, bit 4 = receive, bit 5 = transmit. A 0 bit blocks its source, but the source's pending flag is kept. A write through `mask_we`/`mask_wdata` is visible on `mask_q` after the next rising edge.
- R6: While `gie_q` is 0, no maskable source raises `irq_req`. `gie_set` sets `gie_q` and `gie_clr` clears it, each on the next rising edge.
- R7: When several unmasked sources are pending, the fixed priority from highest to lowest is pin 0, pin 1, pin 2, timer, receive, transmit. `irq_vec` carries the source's bit position from R5 (0 to 5).
- R8: An acknowledge (`irq_ack` high while `irq_req` is high) clears only the pending flag of the source shown on `irq_vec`. Other pending sources stay pending.
- R9: An acknowledge clears `gie_q` on the same rising edge. This takes precedence over `gie_set`.
- R10: If a new event arrives from the source being acknowledged in the same cycle as the acknowledge, that event stays pending.
- R11: A one-cycle `sw_trap` pulse raises `irq_req` with `irq_vec` = 7 after the next rising edge. This happens whatever the mask and `gie_q`, and it takes priority over all maskable sources. Its acknowledge clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 3 | External interrupt pins, active low, asynchronous |
| ext_edge_sel | input | 3 | Per pin: 1 = falling-edge sensing, 0 = low-level sensing |
| tmr_uflow | input | 1 | Timer underflow strobe |
| sp_rx_done | input | 1 | Serial receive complete strobe |
| sp_tx_done | input | 1 | Serial transmit complete strobe |
| sw_trap | input | 1 | Software trap strobe, not maskable |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 6 | Mask register write data |
| mask_q | output | 6 | Mask register contents |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| gie_q | output | 1 | Global enable state |
| irq_req | output | 1 | Interrupt request to the sequencer |
| irq_vec | output | 3 | Vector: 0..5 maskable source, 7 software trap |
| irq_ack | input | 1 | Acknowledge of the shown request |

## Verification
Each result has a fixed latency:
- An edge-mode pin request is due three rising edges after the pin falls.
- A level-mode pin request is due two rising edges after the pin changes, and it is withdrawn two edges after the pin is released.
- Peripheral strobes, the software trap, mask writes, enable changes and acknowledges take effect one edge later.

The driver changes inputs on falling edges and advances exactly the number of edges the relevant latency requires before it queues the expected request, vector and mask. The monitor compares each queued item one nanosecond after that same falling edge, so every sample lands between two active edges.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned EXT_N  = 3;
  localparam int unsigned INT_N  = 3;
  localparam int unsigned SRC_N  = EXT_N + INT_N;
  localparam int unsigned VEC_W  = 3;
  typedef logic [VEC_W-1:0] vec_t;
  // source positions, also the maskable vector numbers (order = priority)
  localparam vec_t VEC_TMR = vec_t'(EXT_N);
  localparam vec_t VEC_RX  = vec_t'(EXT_N + 1);
  localparam vec_t VEC_TX  = vec_t'(EXT_N + 2);
  localparam vec_t VEC_SWI = vec_t'(7);
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q, chain_nx;

  always_comb begin
    chain_nx = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_nx;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/intc_extcap.sv
module intc_extcap #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_s_n,    // synchronised, active low
  input  logic [N-1:0] edge_mode,
  input  logic [N-1:0] clr,
  output logic [N-1:0] act
);
  logic [N-1:0] prev_q, latch_q, latch_nx, fall;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_comb begin
      fall[i] = prev_q[i] & ~pin_s_n[i];
      if (!edge_mode[i]) latch_nx[i] = 1'b0;
      else               latch_nx[i] = (latch_q[i] & ~clr[i]) | fall[i];
      act[i] = edge_mode[i] ? latch_q[i] : ~pin_s_n[i];
    end

    // R2: a latched edge survives until it is acknowledged
    p_edge_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode[i] && latch_q[i] && !clr[i]) |=> (latch_q[i] || !edge_mode[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      latch_q <= '0;
    end else begin
      prev_q  <= pin_s_n;
      latch_q <= latch_nx;
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int unsigned N = 6,
  parameter int unsigned W = 3
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx,
  output logic [N-1:0] grant
);
  always_comb begin
    any   = |req;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx      = W'(i);
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXT_N-1:0] ext_pin_n,
  input  logic [EXT_N-1:0] ext_edge_sel,
  input  logic             tmr_uflow,
  input  logic             sp_rx_done,
  input  logic             sp_tx_done,
  input  logic             sw_trap,
  input  logic             mask_we,
  input  logic [SRC_N-1:0] mask_wdata,
  output logic [SRC_N-1:0] mask_q,
  input  logic             gie_set,
  input  logic             gie_clr,
  output logic             gie_q,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  input  logic             irq_ack
);
  logic [EXT_N-1:0] pin_s_n, ext_act;
  logic [INT_N-1:0] int_pend_q, int_pend_nx, int_evt;
  logic [SRC_N-1:0] src_act, elig, grant, clr_src, mask_nx;
  logic             any, swi_q, swi_nx, gie_nx, take, mask_en;
  logic [VEC_W-1:0] idx;

  intc_sync #(.WIDTH(EXT_N), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin_n), .q(pin_s_n));

  intc_extcap #(.N(EXT_N)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin_s_n(pin_s_n), .edge_mode(ext_edge_sel),
    .clr(clr_src[EXT_N-1:0]), .act(ext_act));

  intc_arb #(.N(SRC_N), .W(VEC_W)) u_arb (
    .req(elig), .any(any), .idx(idx), .grant(grant));

  // source vector: pins low, then timer, receive, transmit
  always_comb begin
    int_evt = {sp_tx_done, sp_rx_done, tmr_uflow};
    src_act = {int_pend_q, ext_act};
    elig    = src_act & mask_q & {SRC_N{gie_q}};
    irq_req = swi_q | any;
    irq_vec = swi_q ? VEC_SWI : idx;
    take    = irq_ack & irq_req;
    clr_src = (take && !swi_q) ? grant : '0;
  end

  // next state
  always_comb begin
    int_pend_nx = (int_pend_q & ~clr_src[SRC_N-1:EXT_N]) | int_evt;
    swi_nx      = (swi_q & ~(take & swi_q)) | sw_trap;
    mask_en     = mask_we;
    mask_nx     = mask_en ? mask_wdata : mask_q;
    if (take)         gie_nx = 1'b0;
    else if (gie_set) gie_nx = 1'b1;
    else if (gie_clr) gie_nx = 1'b0;
    else              gie_nx = gie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_pend_q <= '0;
      swi_q      <= 1'b0;
      mask_q     <= '0;
      gie_q      <= 1'b0;
    end else begin
      int_pend_q <= int_pend_nx;
      swi_q      <= swi_nx;
      if (mask_en) mask_q <= mask_nx;
      gie_q      <= gie_nx;
    end
  end

  p_tmr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_uflow |=> src_act[VEC_TMR]);
  p_mask_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(mask_wdata)));
  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec != VEC_SWI) |-> (gie_q && mask_q[irq_vec]));
  p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec != VEC_SWI) |->
      ((elig & ((SRC_N'(1) << irq_vec) - SRC_N'(1))) == '0));
  p_gie_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !gie_q);
  p_swi_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trap |=> (irq_req && irq_vec == VEC_SWI));
endmodule

// File: tb/intc_core_test.sv
`timescale 1ns/1ps
module intc_core_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ext_pin_n, ext_edge_sel;
  logic       tmr_uflow, sp_rx_done, sp_tx_done, sw_trap;
  logic       mask_we, gie_set, gie_clr, irq_ack;
  logic [5:0] mask_wdata, mask_q;
  logic       gie_q, irq_req;
  logic [2:0] irq_vec;

  int total = 0;
  int bad   = 0;
  logic [5:0] mask_model = '0;

  typedef struct {
    logic       req;
    logic [2:0] vec;
    logic [5:0] mask;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  intc_core uut (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(ext_pin_n), .ext_edge_sel(ext_edge_sel),
    .tmr_uflow(tmr_uflow), .sp_rx_done(sp_rx_done), .sp_tx_done(sp_tx_done),
    .sw_trap(sw_trap), .mask_we(mask_we), .mask_wdata(mask_wdata), .mask_q(mask_q),
    .gie_set(gie_set), .gie_clr(gie_clr), .gie_q(gie_q), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_ack(irq_ack));

  // monitor: pops expectations 1 ns after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (irq_req !== e.req || (e.req && irq_vec !== e.vec) || mask_q !== e.mask) begin
        bad++;
        $display("FAIL %s: req=%b vec=%0d mask=%h expected req=%b vec=%0d mask=%h",
                 e.tag, irq_req, irq_vec, mask_q, e.req, e.vec, e.mask);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic want(input logic req, input logic [2:0] vec, input string tag);
    exp_t e;
    e.req = req; e.vec = vec; e.mask = mask_model; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic set_mask(input logic [5:0] v);
    mask_wdata = v; mask_we = 1'b1; step(1); mask_we = 1'b0; mask_model = v;
  endtask

  task automatic gie_on();
    gie_set = 1'b1; step(1); gie_set = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; step(1); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_pin_n = '1; ext_edge_sel = '1;
    tmr_uflow = 0; sp_rx_done = 0; sp_tx_done = 0; sw_trap = 0;
    mask_we = 0; mask_wdata = '0; gie_set = 0; gie_clr = 0; irq_ack = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
    want(1'b0, 3'd0, "R1 reset state");
    step(1);
    if (gie_q !== 1'b0) begin bad++; $display("FAIL R1 gie=%b expected 0", gie_q); end
    total++;

    // R6 / R8 / R9: single timer source, enable gating and ack
    set_mask(6'h3F);
    want(1'b0, 3'd0, "R5 mask write visible");
    tmr_uflow = 1; step(1); tmr_uflow = 0;
    want(1'b0, 3'd0, "R6 no request while gie=0");
    gie_on();
    want(1'b1, 3'd3, "R4 R6 timer request after gie_set");
    ack();
    want(1'b0, 3'd0, "R9 ack drops gie");
    gie_on();
    want(1'b0, 3'd0, "R8 timer pending cleared by ack");

    // R7 priority with every source pending, gie still 1 -> clear first
    gie_clr = 1; step(1); gie_clr = 0;
    ext_pin_n[0] = 0; tmr_uflow = 1; sp_rx_done = 1; sp_tx_done = 1;
    step(1);
    tmr_uflow = 0; sp_rx_done = 0; sp_tx_done = 0;
    step(2);
    want(1'b0, 3'd0, "R6 all pending but gie=0");
    gie_on();  want(1'b1, 3'd0, "R7 pin0 highest");
    ack();     want(1'b0, 3'd0, "R9 ack clears gie");
    gie_on();  want(1'b1, 3'd3, "R7 R8 timer next");
    ack(); gie_on(); want(1'b1, 3'd4, "R7 receive next");
    ack(); gie_on(); want(1'b1, 3'd5, "R7 transmit last");
    ack(); gie_on(); want(1'b0, 3'd0, "R2 one request per edge with pin held low");
    ext_pin_n[0] = 1; step(3);
    want(1'b0, 3'd0, "R2 pin release adds nothing");

    // R10: event during its own acknowledge
    sp_rx_done = 1; step(1); sp_rx_done = 0;
    want(1'b1, 3'd4, "R4 receive request");
    irq_ack = 1; sp_rx_done = 1; step(1); irq_ack = 0; sp_rx_done = 0;
    want(1'b0, 3'd0, "R9 gie cleared");
    gie_on(); want(1'b1, 3'd4, "R10 new event kept through ack");
    ack(); gie_on(); want(1'b0, 3'd0, "R8 receive now clear");

    // R3 level mode on pin 1
    ext_edge_sel[1] = 0; ext_pin_n[1] = 0;
    step(1); want(1'b0, 3'd0, "R3 one edge after pin low");
    step(1); want(1'b1, 3'd1, "R3 level request after two edges");
    ack();   want(1'b0, 3'd0, "R9 gie off after level ack");
    gie_on(); want(1'b1, 3'd1, "R3 ack does not clear level source");
    ext_pin_n[1] = 1;
    step(1); want(1'b1, 3'd1, "R3 still active one edge after release");
    step(1); want(1'b0, 3'd0, "R3 withdrawn two edges after release");
    ext_edge_sel[1] = 1; step(2);

    // R5 mask holds pending
    set_mask(6'h37);
    tmr_uflow = 1; step(1); tmr_uflow = 0;
    want(1'b0, 3'd0, "R5 masked timer blocked");
    set_mask(6'h3F);
    want(1'b1, 3'd3, "R5 pending kept, shown when unmasked");
    ack(); want(1'b0, 3'd0, "R8 after timer ack");

    // R4 transmit alone
    gie_on();
    sp_tx_done = 1; step(1); sp_tx_done = 0;
    want(1'b1, 3'd5, "R4 transmit request");
    ack();

    // R11 software trap
    set_mask(6'h00);
    sw_trap = 1; step(1); sw_trap = 0;
    want(1'b1, 3'd7, "R11 trap with mask 0 and gie 0");
    ack(); want(1'b0, 3'd0, "R11 trap cleared by ack");
    set_mask(6'h3F); gie_on();
    sw_trap = 1; tmr_uflow = 1; step(1); sw_trap = 0; tmr_uflow = 0;
    want(1'b1, 3'd7, "R11 trap beats timer");
    ack(); want(1'b0, 3'd0, "R9 gie off after trap ack");
    gie_on(); want(1'b1, 3'd3, "R8 timer survives trap ack");
    ack();

    // R2 short low pulse on pin 2
    gie_on();
    ext_pin_n[2] = 0; step(1); ext_pin_n[2] = 1;
    step(1); want(1'b0, 3'd0, "R2 not yet at second edge");
    step(1); want(1'b1, 3'd2, "R2 edge latched at third edge");
    step(2); want(1'b1, 3'd2, "R2 stays pending with pin high");
    ack();   want(1'b0, 3'd0, "R8 pin2 cleared");

    step(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule